// File: doc/BRIEF.md
# Multi-Mode Shift and Rotate Unit

This execution unit moves the bits of a byte, word or long operand left or right under one of four disciplines: arithmetic shift, logical shift, plain rotate, and rotate through the extend bit. It takes its count from a 3-bit immediate field or from a register value, and it also has a memory form that always shifts a word by one position. It returns the shifted result together with the extend (X), negative (N), zero (Z), overflow (V) and carry (C) flags.

The unit moves one bit per clock, so a register count of up to 63 costs no more logic than a count of 1. A caller presents the operand and the controls with a one-cycle `start` pulse. It then waits for the single-cycle `done` pulse, and the result and flags stay valid until the next operation completes. Operand fetch and write-back are handled by the surrounding pipeline.

Top module: `shift_rotate_unit`

## Requirements
- R1: `kind` selects the operation: 00 arithmetic shift (a right shift copies the MSB in, a left shift feeds 0), 01 logical shift (0 fed in), 11 rotate (the bit that leaves re-enters at the other end), 10 rotate through extend (X is a bit of the loop, which is one bit wider than the operand). `dir_left` = 1 shifts toward the MSB and 0 toward the LSB.
- R2: `size` 00 works on bits 7:0, 01 on bits 15:0, and 10 on bits 31:0. Result bits above the selected size equal the operand bits.
- R3: With `count_from_reg` = 0 the count is `count_imm`, where 0 stands for 8. With `count_from_reg` = 1 the count is `count_reg` modulo 64.
- R4: C is the last bit shifted out. For a zero count C is 0, except for rotate through extend, where C takes `x_in`.
- R5: For both shifts and for rotate through extend, X is the last bit shifted out. X equals `x_in` for a zero count, and always for plain rotate.
- R6: For the arithmetic shift, V is 1 when the MSB at the selected size changed at any step. V is 0 for the other three kinds.
- R7: N is the result MSB at the selected size. Z is 1 when the result is zero at the selected size.
- R8: With `mem_form` = 1 the operation uses word size and a count of exactly 1, whatever `size` and the count inputs hold.
- R9: `done` is a one-cycle pulse in the (n+1)th cycle after the cycle in which `start` was sampled, where n is the count. A zero count therefore completes in the cycle right after `start`. `busy` is high while bits are being moved.
- R10: `start` is ignored while `busy` is high. The running operation finishes with its own operands and timing.
- R11: After a synchronous reset, `busy`, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| operand | input | 32 | Value to shift or rotate |
| size | input | 2 | 00 byte, 01 word, 10 long |
| kind | input | 2 | 00 arithmetic, 01 logical, 11 rotate, 10 rotate through X |
| dir_left | input | 1 | 1 left, 0 right |
| count_from_reg | input | 1 | 1 selects count_reg, 0 selects count_imm |
| count_imm | input | 3 | Immediate count, 0 means 8 |
| count_reg | input | 32 | Register count, used modulo 64 |
| mem_form | input | 1 | Word shift by one, overriding size and count |
| x_in | input | 1 | Current extend flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Shifted or rotated value |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The assertions assume that `start` is only pulsed for a single cycle. They also assume that `size` is never 11 and that the controls are steady in the cycle `start` is sampled, because the unit captures them only at that edge. The stimulus holds all controls constant around each pulse and draws random sizes only from the three legal codes. The one deliberate exception is a second `start` during a run, which the bench sends on purpose to show that it is ignored.

// File: rtl/sru_pkg.sv
`timescale 1ns/1ps
package sru_pkg;
  localparam int OPND_W = 32;
  localparam int CNT_W  = 6;
  localparam int IMM_W  = 3;

  typedef enum logic [1:0] {
    K_ASH = 2'b00,
    K_LSH = 2'b01,
    K_RXT = 2'b10,
    K_ROT = 2'b11
  } kind_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} state_e;
endpackage

// File: rtl/sru_count.sv
`timescale 1ns/1ps
module sru_count
  import sru_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CW    = CNT_W,
  parameter int IW    = IMM_W
) (
  input  logic          use_reg,
  input  logic          mem_form,
  input  logic [IW-1:0] imm,
  input  logic [REG_W-1:0] regval,
  output logic [CW-1:0] cnt
);
  localparam int IMM_ZERO_MEANS = 1 << IW;
  localparam int CNT_MOD        = 1 << CW;

  always_comb begin
    if (mem_form) begin
      cnt = CW'(1);
    end else if (use_reg) begin
      cnt = CW'(regval % REG_W'(CNT_MOD));
    end else if (imm == '0) begin
      cnt = CW'(IMM_ZERO_MEANS);
    end else begin
      cnt = CW'(imm);
    end
  end
endmodule

// File: rtl/sru_step.sv
`timescale 1ns/1ps
module sru_step
  import sru_pkg::*;
#(
  parameter int W = OPND_W
) (
  input  logic [W-1:0] cur,
  input  logic         xbit,
  input  logic [1:0]   size,
  input  kind_e        kind,
  input  logic         left,
  output logic [W-1:0] nxt,
  output logic         out_bit,
  output logic         msb_flip
);
  localparam int NSZ  = 3;
  localparam int BASE = W >> (NSZ - 1);

  logic [W-1:0]   cand [NSZ];
  logic [NSZ-1:0] cand_out;
  logic [NSZ-1:0] cand_flip;

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int SW = BASE << g;
    logic [SW-1:0] fld;
    logic [SW-1:0] sh;
    logic          fill;
    logic          ob;

    always_comb begin
      fld = cur[SW-1:0];
      if (left) begin
        case (kind)
          K_ROT:   fill = fld[SW-1];
          K_RXT:   fill = xbit;
          default: fill = 1'b0;
        endcase
        sh = {fld[SW-2:0], fill};
        ob = fld[SW-1];
      end else begin
        case (kind)
          K_ASH:   fill = fld[SW-1];
          K_ROT:   fill = fld[0];
          K_RXT:   fill = xbit;
          default: fill = 1'b0;
        endcase
        sh = {fill, fld[SW-1:1]};
        ob = fld[0];
      end
    end

    assign cand_out[g]  = ob;
    assign cand_flip[g] = sh[SW-1] ^ fld[SW-1];

    if (SW < W) begin : g_part
      assign cand[g] = {cur[W-1:SW], sh};
    end else begin : g_full
      assign cand[g] = sh;
    end
  end

  always_comb begin
    case (size)
      SZ_BYTE: begin nxt = cand[0]; out_bit = cand_out[0]; msb_flip = cand_flip[0]; end
      SZ_WORD: begin nxt = cand[1]; out_bit = cand_out[1]; msb_flip = cand_flip[1]; end
      default: begin nxt = cand[2]; out_bit = cand_out[2]; msb_flip = cand_flip[2]; end
    endcase
  end
endmodule

// File: rtl/sru_flags.sv
`timescale 1ns/1ps
module sru_flags
  import sru_pkg::*;
#(
  parameter int W = OPND_W
) (
  input  logic [W-1:0] res,
  input  logic [1:0]   size,
  output logic         neg,
  output logic         zero
);
  localparam int BW = W / 4;
  localparam int WW = W / 2;

  always_comb begin
    case (size)
      SZ_BYTE: begin neg = res[BW-1]; zero = ~|res[BW-1:0]; end
      SZ_WORD: begin neg = res[WW-1]; zero = ~|res[WW-1:0]; end
      default: begin neg = res[W-1];  zero = ~|res;         end
    endcase
  end
endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W = OPND_W,
  parameter int CW     = CNT_W,
  parameter int IW     = IMM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        size,
  input  logic [1:0]        kind,
  input  logic              dir_left,
  input  logic              count_from_reg,
  input  logic [IW-1:0]     count_imm,
  input  logic [DATA_W-1:0] count_reg,
  input  logic              mem_form,
  input  logic              x_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              flag_x,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  localparam int BW = DATA_W / 4;

  state_e            state;
  logic [DATA_W-1:0] work;
  logic [CW-1:0]     remaining;
  logic [1:0]        size_q;
  kind_e             kind_q;
  logic              left_q;
  logic              xq;
  logic              vacc;

  logic [CW-1:0]     cnt;
  logic [1:0]        eff_size;
  logic [DATA_W-1:0] step_nxt;
  logic              step_out;
  logic              step_flip;
  logic [DATA_W-1:0] flag_src;
  logic [1:0]        flag_sz;
  logic              nz_neg;
  logic              nz_zero;
  kind_e             kind_in;

  assign kind_in  = kind_e'(kind);
  assign eff_size = mem_form ? SZ_WORD : size;
  assign busy     = (state == S_RUN);

  sru_count #(.REG_W(DATA_W), .CW(CW), .IW(IW)) u_count (
    .use_reg (count_from_reg),
    .mem_form(mem_form),
    .imm     (count_imm),
    .regval  (count_reg),
    .cnt     (cnt)
  );

  sru_step #(.W(DATA_W)) u_step (
    .cur     (work),
    .xbit    (xq),
    .size    (size_q),
    .kind    (kind_q),
    .left    (left_q),
    .nxt     (step_nxt),
    .out_bit (step_out),
    .msb_flip(step_flip)
  );

  assign flag_src = (state == S_IDLE) ? operand  : step_nxt;
  assign flag_sz  = (state == S_IDLE) ? eff_size : size_q;

  sru_flags #(.W(DATA_W)) u_flags (
    .res (flag_src),
    .size(flag_sz),
    .neg (nz_neg),
    .zero(nz_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      work      <= '0;
      remaining <= '0;
      size_q    <= SZ_BYTE;
      kind_q    <= K_ASH;
      left_q    <= 1'b0;
      xq        <= 1'b0;
      vacc      <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      flag_x    <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            work      <= operand;
            remaining <= cnt;
            size_q    <= eff_size;
            kind_q    <= kind_in;
            left_q    <= dir_left;
            xq        <= x_in;
            vacc      <= 1'b0;
            if (cnt == '0) begin
              result <= operand;
              flag_x <= x_in;
              flag_c <= (kind_in == K_RXT) ? x_in : 1'b0;
              flag_v <= 1'b0;
              flag_n <= nz_neg;
              flag_z <= nz_zero;
              done   <= 1'b1;
            end else begin
              state <= S_RUN;
            end
          end
        end
        S_RUN: begin
          work      <= step_nxt;
          remaining <= remaining - 1'b1;
          vacc      <= vacc | step_flip;
          if (kind_q == K_RXT) xq <= step_out;
          if (remaining == CW'(1)) begin
            result <= step_nxt;
            flag_x <= (kind_q == K_ROT) ? xq : step_out;
            flag_c <= step_out;
            flag_v <= (kind_q == K_ASH) & (vacc | step_flip);
            flag_n <= nz_neg;
            flag_z <= nz_zero;
            done   <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  v_other_kinds_chk: assert property (@(posedge clk) disable iff (rst)
    done && (kind_q != K_ASH) |-> !flag_v);

  // R5
  rot_x_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) && (kind_q != K_RXT) |=> $stable(xq));

  // R2
  upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) && (size_q == SZ_BYTE) |=> work[DATA_W-1:BW] == $past(work[DATA_W-1:BW]));

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) && start && (cnt == '0) |=> done && !busy);

  // R9
  last_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) && (remaining == CW'(1)) |=> done && !busy);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) && (remaining > CW'(1)) |=>
      busy && (remaining == $past(remaining) - 1'b1) && (kind_q == $past(kind_q)));

  // R8
  mem_form_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) && start && mem_form |=> busy && (remaining == CW'(1)) && (size_q == SZ_WORD));
endmodule

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] operand;
  logic [1:0]  size;
  logic [1:0]  kind;
  logic        dir_left;
  logic        count_from_reg;
  logic [2:0]  count_imm;
  logic [31:0] count_reg;
  logic        mem_form;
  logic        x_in;
  logic        busy, done;
  logic [31:0] result;
  logic        flag_x, flag_n, flag_z, flag_v, flag_c;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  shift_rotate_unit uut (
    .clk(clk), .rst(rst), .start(start), .operand(operand), .size(size), .kind(kind),
    .dir_left(dir_left), .count_from_reg(count_from_reg), .count_imm(count_imm),
    .count_reg(count_reg), .mem_form(mem_form), .x_in(x_in), .busy(busy), .done(done),
    .result(result), .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: packs {result, x, n, z, v, c}
  function automatic logic [36:0] ref_op(input logic [31:0] op, input logic [1:0] sz,
      input logic [1:0] kd, input logic lf, input int n, input logic xi);
    int w;
    logic [31:0] v;
    logic x, c, ov, b, hi, lo, fill;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    v = op; x = xi; c = 1'b0; ov = 1'b0;
    for (int i = 0; i < n; i++) begin
      hi = v[w-1]; lo = v[0];
      if (lf) begin
        b = hi;
        fill = (kd == 2'b11) ? hi : (kd == 2'b10) ? x : 1'b0;
        for (int j = w - 1; j > 0; j--) v[j] = v[j-1];
        v[0] = fill;
      end else begin
        b = lo;
        fill = (kd == 2'b00) ? hi : (kd == 2'b11) ? lo : (kd == 2'b10) ? x : 1'b0;
        for (int j = 0; j < w - 1; j++) v[j] = v[j+1];
        v[w-1] = fill;
      end
      if (v[w-1] != hi) ov = 1'b1;
      c = b;
      if (kd != 2'b11) x = b;
    end
    if (n == 0) c = (kd == 2'b10) ? xi : 1'b0;
    begin
      logic [31:0] mask;
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
      return {v, x, v[w-1], ((v & mask) == 0), (kd == 2'b00) ? ov : 1'b0, c};
    end
  endfunction

  task automatic drive(input logic [31:0] op, input logic [1:0] sz, input logic [1:0] kd,
      input logic lf, input logic ur, input logic [2:0] im, input logic [31:0] rv,
      input logic mf, input logic xi);
    operand = op; size = sz; kind = kd; dir_left = lf; count_from_reg = ur;
    count_imm = im; count_reg = rv; mem_form = mf; x_in = xi;
  endtask

  task automatic run_op(input string tag, input logic [31:0] op, input logic [1:0] sz,
      input logic [1:0] kd, input logic lf, input logic ur, input logic [2:0] im,
      input logic [31:0] rv, input logic mf, input logic xi);
    int n, lat;
    logic [1:0] esz;
    logic [36:0] e;
    n   = mf ? 1 : ur ? int'(rv % 64) : ((im == 0) ? 8 : int'(im));
    esz = mf ? 2'b01 : sz;
    e   = ref_op(op, esz, kd, lf, n, xi);
    @(negedge clk);
    drive(op, sz, kd, lf, ur, im, rv, mf, xi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check({tag, " R9 latency"}, 64'(lat), 64'(n + 1));
    check({tag, " R1 R2 R3 result"}, 64'(result), 64'(e[36:5]));
    check({tag, " R4 R5 R6 R7 flags xnzvc"}, 64'({flag_x, flag_n, flag_z, flag_v, flag_c}),
          64'(e[4:0]));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; start = 1'b0;
    drive(32'h0, 2'b00, 2'b00, 1'b0, 1'b0, 3'd1, 32'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", 64'({busy, done, result, flag_x, flag_n, flag_z, flag_v, flag_c}), 64'(0));
    rst = 1'b0;

    // R6 ASL byte 0x40 by 1: MSB changes
    run_op("asl1", 32'h0000_0040, 2'b00, 2'b00, 1'b1, 1'b0, 3'd1, 0, 1'b0, 1'b0);
    check("R6 asl byte V set", 64'({result[7:0], flag_v, flag_n, flag_c}), 64'({8'h80, 3'b110}));
    // R6 ASL byte 0x81 by 2: change only in first step, V stays set
    run_op("asl2", 32'h0000_0081, 2'b00, 2'b00, 1'b1, 1'b0, 3'd2, 0, 1'b0, 1'b0);
    check("R6 asl sticky V", 64'({result[7:0], flag_v}), 64'({8'h04, 1'b1}));
    // R3 immediate 0 means 8, R9 latency 9
    run_op("lsr8", 32'h1234_FFFF, 2'b01, 2'b01, 1'b0, 1'b0, 3'd0, 0, 1'b0, 1'b0);
    check("R3 imm0 is 8", 64'(result), 64'(32'h1234_00FF));
    // R3 register count modulo 64: 65 -> 1
    run_op("mod64", 32'h0000_0001, 2'b10, 2'b01, 1'b1, 1'b1, 3'd0, 65, 1'b0, 1'b0);
    check("R3 reg mod 64", 64'(result), 64'(32'h2));
    // R4 zero count rotate through extend: C = X
    run_op("roxz", 32'h0000_0000, 2'b10, 2'b10, 1'b1, 1'b1, 3'd0, 64, 1'b0, 1'b1);
    check("R4 zero count rox C", 64'({flag_c, flag_x}), 64'(2'b11));
    // R4 R5 zero count shift: C cleared, X unchanged
    run_op("lslz", 32'h8000_0000, 2'b10, 2'b01, 1'b1, 1'b1, 3'd0, 128, 1'b0, 1'b1);
    check("R5 zero count shift X keep", 64'({flag_c, flag_x, flag_n}), 64'(3'b011));
    // R5 rotate leaves X alone
    run_op("rolx", 32'h8000_0001, 2'b10, 2'b11, 1'b1, 1'b0, 3'd1, 0, 1'b0, 1'b0);
    check("R5 rol X untouched", 64'({result, flag_x, flag_c}), 64'({32'h0000_0003, 2'b01}));
    // R1 rotate through extend right, long: loop of 33
    run_op("roxr", 32'h0000_0001, 2'b10, 2'b10, 1'b0, 1'b0, 3'd1, 0, 1'b0, 1'b1);
    check("R1 roxr", 64'({result, flag_x}), 64'({32'h8000_0000, 1'b1}));
    // R1 ASR sign fill, R7 N at byte
    run_op("asr", 32'hABCD_EF80, 2'b00, 2'b00, 1'b0, 1'b0, 3'd3, 0, 1'b0, 1'b0);
    check("R2 R7 asr byte", 64'({result, flag_n}), 64'({32'hABCD_EFF0, 1'b1}));
    // R8 memory form overrides size and count
    run_op("mem", 32'hFFFF_C001, 2'b00, 2'b01, 1'b0, 1'b1, 3'd5, 10, 1'b1, 1'b0);
    check("R8 mem form", 64'({result, flag_c}), 64'({32'hFFFF_6000, 1'b1}));
    // R7 Z at word size with upper bits set
    run_op("zword", 32'h5555_8000, 2'b01, 2'b01, 1'b1, 1'b0, 3'd1, 0, 1'b0, 1'b0);
    check("R7 Z word", 64'({result, flag_z}), 64'({32'h5555_0000, 1'b1}));

    // R10 start while busy is ignored
    begin
      int lat;
      @(negedge clk);
      drive(32'h0000_0001, 2'b10, 2'b01, 1'b1, 1'b1, 3'd0, 20, 1'b0, 1'b0);
      start = 1'b1;
      @(negedge clk); start = 1'b0; lat = 1;
      repeat (3) begin @(negedge clk); lat++; end
      drive(32'hFFFF_FFFF, 2'b00, 2'b11, 1'b0, 1'b0, 3'd1, 0, 1'b0, 1'b1);
      start = 1'b1;
      @(negedge clk); start = 1'b0; lat++;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      check("R10 busy start latency", 64'(lat), 64'(21));
      check("R10 busy start result", 64'(result), 64'(32'h0010_0000));
      @(negedge clk);
      check("R10 no extra done", 64'({done, busy}), 64'(0));
    end

    // Random mix
    for (int i = 0; i < 200; i++) begin
      logic [31:0] op, rv;
      logic [1:0] sz, kd;
      op = $urandom; rv = $urandom % 256;
      sz = 2'($urandom % 3); kd = 2'($urandom);
      run_op($sformatf("rnd%0d", i), op, sz, kd, 1'($urandom), 1'($urandom), 3'($urandom),
             rv, ($urandom % 16) == 0, 1'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule